// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs a single DMA channel. Software loads a source address, a destination address, a unit count and a small set of mode bits, then raises the channel enable and the global master enable. For each unit, the sequencer reads from the source address and then writes to the destination address over a simple memory master port. It advances both addresses by the unit size and decrements the count. A unit can be started by the block itself (auto mode), by an external request line, or by a request line from another on-chip module.

The channel stops in one of two ways. It stops normally when the count reaches zero: it raises a sticky end flag and, if the interrupt enable is set, an interrupt. It stops early on an NMI, on a memory error response, or when either enable is dropped. A unit that an abort cuts short does not count. Neither its count step nor its address step is applied, so the same unit is repeated once the channel runs again.

The bus mode sets how the bus is used:
- In burst mode the master port stays busy from the first unit to the last.
- In cycle-steal mode the port goes idle for one cycle after every unit. In the request-line modes, a fresh trigger is also needed for every unit.

Top module: `dma_chan_seq`

## Requirements
- R1: A unit starts only if all of these hold: chanEn=1, masterEn=1, endFlag=0, addrErrFlag=0, nmiFlag=0, nmi=0 and the remaining count is nonzero. A loaded count of 0 never starts.
- R2: cfgMode selects the trigger, sampled while the port is idle: 00 starts with no trigger; 01 needs extReq=1; 10 needs modReq=1; 11 never starts. A request line that the mode does not select has no effect.
- R3: A unit is one read phase at the source address (memWrite=0) followed by one write phase at the destination address (memWrite=1). memSize equals cfgSize. Both addresses advance by 1, 2, 4 or 16 bytes for cfgSize 00, 01, 10 or 11. remCount falls by one on the cycle after each accepted write.
- R4: When the last unit's write is accepted, remCount is 0 and endFlag is set. endFlag stays set until a clrEnd pulse.
- R5: irq equals endFlag AND the loaded interrupt enable (cfgIntEn).
- R6: nmi=1 aborts the current unit at once and sets nmiFlag. nmiFlag blocks any start until clrNmi.
- R7: Dropping chanEn or masterEn aborts the unit in progress. The unit is discarded: remCount and both addresses are unchanged, and the same unit is redone when the channel is re-enabled.
- R8: memErr during a phase sets addrErrFlag and stops the channel. addrErrFlag blocks any start until clrAddrErr.
- R9: In burst mode (cfgBurst=1), the next read phase follows directly after an accepted write, with no further trigger needed. In cycle-steal mode (cfgBurst=0), memValid is low for exactly one cycle between units in auto mode, and each unit needs its own trigger.
- R10: progLoad is taken only while memValid is 0. Asserted during a transfer, it has no effect.
- R11: After reset, memValid, all flags, irq and remCount are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| progLoad | input | 1 | Load strobe for the cfg* values |
| cfgSrc | input | ADDR_W | Source start address |
| cfgDst | input | ADDR_W | Destination start address |
| cfgCount | input | CNT_W | Number of units |
| cfgSize | input | 2 | Unit size code |
| cfgMode | input | 2 | Trigger source code |
| cfgBurst | input | 1 | 1 = burst, 0 = cycle steal |
| cfgIntEn | input | 1 | Completion interrupt enable |
| chanEn | input | 1 | Channel enable |
| masterEn | input | 1 | Global DMA enable |
| extReq | input | 1 | External request line |
| modReq | input | 1 | On-chip module request line |
| nmi | input | 1 | Non-maskable interrupt abort |
| clrEnd | input | 1 | Clears endFlag |
| clrAddrErr | input | 1 | Clears addrErrFlag |
| clrNmi | input | 1 | Clears nmiFlag |
| memValid | output | 1 | Memory phase request |
| memWrite | output | 1 | 1 = write phase, 0 = read phase |
| memAddr | output | ADDR_W | Phase address |
| memSize | output | 2 | Unit size code of the phase |
| memReady | input | 1 | Phase accepted |
| memErr | input | 1 | Address error response |
| remCount | output | CNT_W | Units still to move |
| endFlag | output | 1 | Normal completion flag |
| addrErrFlag | output | 1 | Address error flag |
| nmiFlag | output | 1 | NMI abort flag |
| irq | output | 1 | Completion interrupt |

## Verification
Each phase a test depends on has a known due cycle, and the bench samples exactly there.
- A start condition or trigger that holds at one clock edge raises memValid in the next cycle.
- A phase accepted at an edge moves the port to its next phase in the cycle that follows.
- remCount, endFlag and the abort flags take their new values one edge after the handshake, abort or error that causes them.

The bench drives inputs one time unit after the rising edge. It logs accepted phases with their cycle stamps at the falling edge, so the gap between units can be checked cycle by cycle. It reads flags and counts only after the edge on which they are due.

// File: rtl/dma_chan_seq_pkg.sv
package dma_chan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seqState_t;

  typedef enum logic [1:0] {
    REQ_AUTO = 2'd0,
    REQ_EXT  = 2'd1,
    REQ_MOD  = 2'd2,
    REQ_OFF  = 2'd3
  } reqMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic setEnd;
    logic setAddrErr;
  } dpStrobe_t;

  function automatic logic [4:0] unitBytes(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    return 5'd1;
      2'd1:    return 5'd2;
      2'd2:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_seq_dp.sv
module dma_chan_seq_dp
  import dma_chan_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [1:0]        cfgSize,
  input  logic [1:0]        cfgMode,
  input  logic              cfgBurst,
  input  logic              cfgIntEn,
  input  logic              nmi,
  input  logic              clrEnd,
  input  logic              clrAddrErr,
  input  logic              clrNmi,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic [1:0]        unitSize,
  output reqMode_t          reqMode,
  output logic              burst,
  output logic              intEn,
  output logic              endFlag,
  output logic              addrErrFlag,
  output logic              nmiFlag,
  output logic              countIsZero,
  output logic              countIsOne
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrStep;

  always_comb begin
    addrStep    = ADDR_W'(unitBytes(unitSize));
    countIsZero = (count == '0);
    countIsOne  = (count == CNT_ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      count    <= '0;
      unitSize <= 2'd0;
      reqMode  <= REQ_AUTO;
      burst    <= 1'b0;
      intEn    <= 1'b0;
    end else if (strobe.load) begin
      srcAddr  <= cfgSrc;
      dstAddr  <= cfgDst;
      count    <= cfgCount;
      unitSize <= cfgSize;
      reqMode  <= reqMode_t'(cfgMode);
      burst    <= cfgBurst;
      intEn    <= cfgIntEn;
    end else if (strobe.advance) begin
      srcAddr <= srcAddr + addrStep;
      dstAddr <= dstAddr + addrStep;
      count   <= count - CNT_ONE;
    end
  end

  // sticky flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endFlag     <= 1'b0;
      addrErrFlag <= 1'b0;
      nmiFlag     <= 1'b0;
    end else begin
      if (strobe.setEnd)          endFlag <= 1'b1;
      else if (clrEnd)            endFlag <= 1'b0;
      if (strobe.setAddrErr)      addrErrFlag <= 1'b1;
      else if (clrAddrErr)        addrErrFlag <= 1'b0;
      if (nmi)                    nmiFlag <= 1'b1;
      else if (clrNmi)            nmiFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_seq_ctl.sv
module dma_chan_seq_ctl
  import dma_chan_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      progLoad,
  input  logic      chanEn,
  input  logic      masterEn,
  input  logic      extReq,
  input  logic      modReq,
  input  logic      nmi,
  input  logic      memReady,
  input  logic      memErr,
  input  reqMode_t  reqMode,
  input  logic      burst,
  input  logic      endFlag,
  input  logic      addrErrFlag,
  input  logic      nmiFlag,
  input  logic      countIsZero,
  input  logic      countIsOne,
  output seqState_t state,
  output dpStrobe_t strobe
);

  seqState_t nextState;
  logic      trigger;
  logic      startOk;
  logic      abortNow;

  always_comb begin
    case (reqMode)
      REQ_AUTO: trigger = 1'b1;
      REQ_EXT:  trigger = extReq;
      REQ_MOD:  trigger = modReq;
      default:  trigger = 1'b0;
    endcase
    abortNow = nmi || !chanEn || !masterEn;
    startOk  = chanEn && masterEn && !endFlag && !addrErrFlag &&
               !nmiFlag && !nmi && !countIsZero;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        strobe.load = progLoad;
        if (startOk && trigger) nextState = ST_READ;
      end
      ST_READ: begin
        if (abortNow) begin
          nextState = ST_IDLE;
        end else if (memErr) begin
          strobe.setAddrErr = 1'b1;
          nextState         = ST_IDLE;
        end else if (memReady) begin
          nextState = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (abortNow) begin
          nextState = ST_IDLE;
        end else if (memErr) begin
          strobe.setAddrErr = 1'b1;
          nextState         = ST_IDLE;
        end else if (memReady) begin
          strobe.advance = 1'b1;
          if (countIsOne) begin
            strobe.setEnd = 1'b1;
            nextState     = ST_IDLE;
          end else begin
            nextState = burst ? ST_READ : ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progLoad,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [1:0]        cfgSize,
  input  logic [1:0]        cfgMode,
  input  logic              cfgBurst,
  input  logic              cfgIntEn,
  input  logic              chanEn,
  input  logic              masterEn,
  input  logic              extReq,
  input  logic              modReq,
  input  logic              nmi,
  input  logic              clrEnd,
  input  logic              clrAddrErr,
  input  logic              clrNmi,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  input  logic              memReady,
  input  logic              memErr,
  output logic [CNT_W-1:0]  remCount,
  output logic              endFlag,
  output logic              addrErrFlag,
  output logic              nmiFlag,
  output logic              irq
);

  seqState_t         state;
  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic [1:0]        unitSize;
  reqMode_t          reqMode;
  logic              burst;
  logic              intEn;
  logic              countIsZero;
  logic              countIsOne;

  dma_chan_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .progLoad(progLoad),
    .chanEn(chanEn), .masterEn(masterEn), .extReq(extReq), .modReq(modReq),
    .nmi(nmi), .memReady(memReady), .memErr(memErr),
    .reqMode(reqMode), .burst(burst), .endFlag(endFlag),
    .addrErrFlag(addrErrFlag), .nmiFlag(nmiFlag),
    .countIsZero(countIsZero), .countIsOne(countIsOne),
    .state(state), .strobe(strobe)
  );

  dma_chan_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgSrc(cfgSrc), .cfgDst(cfgDst), .cfgCount(cfgCount),
    .cfgSize(cfgSize), .cfgMode(cfgMode), .cfgBurst(cfgBurst),
    .cfgIntEn(cfgIntEn), .nmi(nmi), .clrEnd(clrEnd),
    .clrAddrErr(clrAddrErr), .clrNmi(clrNmi),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .count(remCount),
    .unitSize(unitSize), .reqMode(reqMode), .burst(burst), .intEn(intEn),
    .endFlag(endFlag), .addrErrFlag(addrErrFlag), .nmiFlag(nmiFlag),
    .countIsZero(countIsZero), .countIsOne(countIsOne)
  );

  always_comb begin
    memValid = (state != ST_IDLE);
    memWrite = (state == ST_WRITE);
    memAddr  = memWrite ? dstAddr : srcAddr;
    memSize  = unitSize;
    irq      = endFlag && intEn;
  end

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic             masterEn,
  input logic             nmi,
  input logic             clrEnd,
  input logic             memValid,
  input logic             memWrite,
  input logic             memReady,
  input logic             memErr,
  input logic [CNT_W-1:0] remCount,
  input logic             endFlag,
  input logic             addrErrFlag,
  input logic             nmiFlag,
  input logic             irq
);

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid) |-> $past(chanEn && masterEn && !endFlag && !addrErrFlag &&
                              !nmiFlag && !nmi && (remCount != '0))); // R1

  AST_UNIT_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memReady && !memErr && chanEn && masterEn && !nmi)
      |=> (remCount == $past(remCount) - CNT_W'(1))); // R3

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && !clrEnd) |=> endFlag); // R4

  AST_IRQ_NEEDS_END: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> endFlag); // R5

  AST_NMI_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    nmi |=> (nmiFlag && !memValid)); // R6

  AST_ENABLE_LOSS_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn || !masterEn) |=> !memValid); // R7

  AST_ADDR_ERR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memErr && chanEn && masterEn && !nmi)
      |=> (addrErrFlag && !memValid)); // R8

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam logic [31:0] SRC0 = 32'h0000_1000;
  localparam logic [31:0] DST0 = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progLoad = 1'b0;
  logic [ADDR_W-1:0] cfgSrc = '0;
  logic [ADDR_W-1:0] cfgDst = '0;
  logic [CNT_W-1:0]  cfgCount = '0;
  logic [1:0] cfgSize = 2'd0;
  logic [1:0] cfgMode = 2'd0;
  logic cfgBurst = 1'b0, cfgIntEn = 1'b0;
  logic chanEn = 1'b0, masterEn = 1'b0, extReq = 1'b0, modReq = 1'b0, nmi = 1'b0;
  logic clrEnd = 1'b0, clrAddrErr = 1'b0, clrNmi = 1'b0;
  logic readyEn = 1'b1, errEn = 1'b0;
  logic memValid, memWrite, memReady, memErr;
  logic [ADDR_W-1:0] memAddr;
  logic [1:0] memSize;
  logic [CNT_W-1:0] remCount;
  logic endFlag, addrErrFlag, nmiFlag, irq;

  assign memReady = memValid && readyEn;
  assign memErr   = memValid && errEn;

  dma_chan_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (.*);

  always #5 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int logN = 0;
  int validSeen = 0;
  logic [31:0] logAddr [0:1023];
  logic        logWr   [0:1023];
  logic [1:0]  logSz   [0:1023];
  int          logCyc  [0:1023];

  // accepted phases, sampled mid-cycle
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (memValid) validSeen = validSeen + 1;
    if (memValid && memReady && !memErr && chanEn && masterEn && !nmi && logN < 1024) begin
      logAddr[logN] = memAddr;
      logWr[logN]   = memWrite;
      logSz[logN]   = memSize;
      logCyc[logN]  = cyc;
      logN = logN + 1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [31:0] src, input logic [31:0] dst, input int cnt,
                      input int sz, input int mode, input bit bst, input bit ie);
    cfgSrc = src; cfgDst = dst; cfgCount = CNT_W'(cnt);
    cfgSize = 2'(sz); cfgMode = 2'(mode); cfgBurst = bst; cfgIntEn = ie;
    progLoad = 1'b1;
    step(1);
    progLoad = 1'b0;
  endtask

  task automatic waitEnd(input int maxCyc);
    for (int t = 0; t < maxCyc && !endFlag; t++) step(1);
  endtask

  task automatic pulseClrEnd();
    clrEnd = 1'b1; step(1); clrEnd = 1'b0;
  endtask

  function automatic int bytesOf(input int sz);
    return (sz == 3) ? 16 : (1 << sz);
  endfunction

  bit finished = 1'b0;

  initial begin
    #1_000_000;
    if (!finished) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int base;
    int snap;
    // ---- reset (R11)
    step(3);
    chk("R11", "memValid", memValid, 0);
    chk("R11", "remCount", remCount, 0);
    chk("R11", "endFlag", endFlag, 0);
    chk("R11", "flags", {addrErrFlag, nmiFlag, irq}, 0);
    rstN = 1'b1;
    step(2);
    chk("R11", "memValid after release", memValid, 0);

    // ---- sweep: size x bus mode x count, auto request (R3 R4 R5 R9)
    masterEn = 1'b1;
    for (int sz = 0; sz < 4; sz++) begin
      for (int b = 0; b < 2; b++) begin
        for (int n = 1; n <= 4; n++) begin
          load(SRC0, DST0, n, sz, 0, b[0], n[0]);
          base = logN;
          chanEn = 1'b1;
          waitEnd(100);
          chanEn = 1'b0;
          chk("R4", "endFlag", endFlag, 1);
          chk("R3", "remCount", remCount, 0);
          chk("R3", "phase count", logN - base, 2 * n);
          for (int k = 0; k < n; k++) begin
            chk("R3", "read addr", logAddr[base + 2*k], SRC0 + k * bytesOf(sz));
            chk("R3", "read dir", logWr[base + 2*k], 0);
            chk("R3", "write addr", logAddr[base + 2*k + 1], DST0 + k * bytesOf(sz));
            chk("R3", "write dir", logWr[base + 2*k + 1], 1);
            chk("R3", "size", logSz[base + 2*k], sz);
            if (k > 0)
              chk("R9", "gap", logCyc[base + 2*k] - logCyc[base + 2*k - 1], b ? 1 : 2);
          end
          chk("R5", "irq", irq, n % 2);
          step(3);
          chk("R4", "endFlag sticky", endFlag, 1);
          pulseClrEnd();
          chk("R4", "endFlag cleared", endFlag, 0);
          chk("R5", "irq cleared", irq, 0);
        end
      end
    end

    // ---- count 0 never starts (R1)
    load(SRC0, DST0, 0, 0, 0, 1'b1, 1'b1);
    snap = validSeen;
    chanEn = 1'b1; step(6); chanEn = 1'b0;
    chk("R1", "zero count activity", validSeen - snap, 0);
    chk("R1", "zero count endFlag", endFlag, 0);

    // ---- masterEn low blocks start (R1)
    load(SRC0, DST0, 2, 0, 0, 1'b1, 1'b0);
    masterEn = 1'b0; snap = validSeen;
    chanEn = 1'b1; step(6);
    chk("R1", "masterEn low activity", validSeen - snap, 0);
    chanEn = 1'b0; masterEn = 1'b1; step(1);

    // ---- external request, cycle steal: one unit per trigger (R2 R9)
    load(SRC0, DST0, 3, 1, 1, 1'b0, 1'b0);
    snap = validSeen; base = logN;
    chanEn = 1'b1; step(6);
    chk("R2", "no trigger activity", validSeen - snap, 0);
    modReq = 1'b1; step(1); modReq = 1'b0; step(6);
    chk("R2", "unselected line ignored", validSeen - snap, 0);
    extReq = 1'b1; step(1); extReq = 1'b0; step(8);
    chk("R9", "one unit per trigger", logN - base, 2);
    chk("R2", "count after one trigger", remCount, 2);
    extReq = 1'b1; step(1); extReq = 1'b0; step(8);
    chk("R2", "second unit dst", logAddr[base + 3], DST0 + 2);
    chk("R2", "count after two triggers", remCount, 1);
    chanEn = 1'b0; step(1);

    // ---- module request, burst: one trigger runs to the end (R2 R9)
    load(SRC0, DST0, 3, 2, 2, 1'b1, 1'b1);
    base = logN; chanEn = 1'b1;
    extReq = 1'b1; step(1); extReq = 1'b0; step(6);
    chk("R2", "ext ignored in module mode", logN - base, 0);
    modReq = 1'b1; step(1); modReq = 1'b0;
    waitEnd(40);
    chk("R9", "burst phases", logN - base, 6);
    chk("R4", "burst endFlag", endFlag, 1);
    chk("R5", "burst irq", irq, 1);
    chanEn = 1'b0; pulseClrEnd();

    // ---- mode 11 never starts (R2)
    load(SRC0, DST0, 2, 0, 3, 1'b1, 1'b0);
    snap = validSeen; chanEn = 1'b1; extReq = 1'b1; modReq = 1'b1; step(6);
    chk("R2", "mode 11 activity", validSeen - snap, 0);
    chanEn = 1'b0; extReq = 1'b0; modReq = 1'b0; step(1);

    // ---- enable loss mid-unit discards the unit (R7)
    load(SRC0, DST0, 4, 2, 0, 1'b0, 1'b0);
    readyEn = 1'b0; base = logN;
    chanEn = 1'b1; step(4);
    chk("R7", "stalled in read", memValid, 1);
    chanEn = 1'b0; step(2);
    chk("R7", "memValid after drop", memValid, 0);
    chk("R7", "count kept", remCount, 4);
    readyEn = 1'b1; chanEn = 1'b1; waitEnd(60); chanEn = 1'b0;
    chk("R7", "redo first read", logAddr[base], SRC0);
    chk("R7", "phases after resume", logN - base, 8);
    pulseClrEnd();

    // masterEn drop during write phase (R7)
    load(SRC0, DST0, 2, 0, 0, 1'b1, 1'b0);
    chanEn = 1'b1; step(2);
    readyEn = 1'b0; step(2);
    chk("R7", "stalled in write", memWrite, 1);
    masterEn = 1'b0; step(2);
    chk("R7", "master drop memValid", memValid, 0);
    chk("R7", "master drop count", remCount, 2);
    readyEn = 1'b1; base = logN; masterEn = 1'b1; waitEnd(40); chanEn = 1'b0;
    chk("R7", "master resume read addr", logAddr[base], SRC0);
    chk("R7", "master resume end", remCount, 0);
    pulseClrEnd();

    // ---- progLoad during a transfer ignored (R10)
    load(SRC0, DST0, 2, 0, 0, 1'b1, 1'b0);
    readyEn = 1'b0; base = logN; chanEn = 1'b1; step(3);
    cfgSrc = 32'hDEAD_0000; cfgCount = CNT_W'(9); progLoad = 1'b1; step(1); progLoad = 1'b0;
    readyEn = 1'b1; waitEnd(40); chanEn = 1'b0;
    chk("R10", "source kept", logAddr[base], SRC0);
    chk("R10", "phases kept", logN - base, 4);
    pulseClrEnd();

    // ---- NMI abort (R6)
    load(SRC0, DST0, 4, 0, 0, 1'b0, 1'b0);
    base = logN; chanEn = 1'b1;
    for (int t = 0; t < 40 && (logN - base) < 2; t++) step(1);
    nmi = 1'b1; step(1); nmi = 1'b0;
    chk("R6", "nmiFlag", nmiFlag, 1);
    chk("R6", "memValid after nmi", memValid, 0);
    snap = validSeen; step(6);
    chk("R6", "blocked while flagged", validSeen - snap, 0);
    clrNmi = 1'b1; step(1); clrNmi = 1'b0;
    chk("R6", "nmiFlag cleared", nmiFlag, 0);
    waitEnd(60); chanEn = 1'b0;
    chk("R6", "resume end", endFlag, 1);
    chk("R6", "last write addr", logAddr[logN - 1], DST0 + 3);
    pulseClrEnd();

    // ---- address error (R8)
    load(SRC0, DST0, 2, 0, 0, 1'b1, 1'b0);
    errEn = 1'b1; chanEn = 1'b1; step(3);
    chk("R8", "addrErrFlag", addrErrFlag, 1);
    chk("R8", "memValid after error", memValid, 0);
    chk("R8", "count kept", remCount, 2);
    errEn = 1'b0; snap = validSeen; step(5);
    chk("R8", "blocked while flagged", validSeen - snap, 0);
    clrAddrErr = 1'b1; step(1); clrAddrErr = 1'b0;
    waitEnd(40); chanEn = 1'b0;
    chk("R8", "completes after clear", remCount, 0);
    pulseClrEnd();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule